// File: doc/BRIEF.md
# Timed Digital Ramp Generator

This block produces a 32-bit unsigned sweep value that a synthesis datapath can use as a frequency, phase or amplitude control word. An accumulator holds the present sweep value. It moves only when a programmable rate timer expires. The rate timer counts ticks of a slow clock enable, which fires once every `CLK_DIV` system clocks. Rising and falling sweeps each have their own step size and their own timer period. A lower and an upper bound limit the sweep. At each bound the sweep either dwells there or snaps back to the opposite bound.

All programmable values are presented on staged inputs. They are copied into the working set only on an update strobe. Two live inputs steer the sweep. One picks the direction. The other freezes the sweep while asserted. A flag output reports that the accumulator sits on the bound it is heading toward.

Top module: `drg_top`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), `ramp_o` is 0 and `at_lim_o` is 0, and the working configuration is all zero (sweep disabled).
- R2: Staged configuration inputs have no effect until a clock edge with `upd_i` high. At that edge all of them are copied into the working set together.
- R3: While the working enable bit is 0, `ramp_o` does not change. The direction, freeze and clear controls and all timers are ignored, and the prescaler and rate timer are held at zero.
- R4: While enabled and rising (`dir_i` = 1), the accumulator adds the rising step once every `P`×`CLK_DIV` clocks, where `P` is the rising period. A period of 0 behaves as 1.
- R5: While enabled and falling (`dir_i` = 0), the accumulator subtracts the falling step once every `P`×`CLK_DIV` clocks, where `P` is the falling period. A period of 0 behaves as 1.
- R6: A rising step whose result would reach or pass the upper bound loads the upper bound. The sum is formed one bit wider, so the value never wraps past all-ones.
- R7: A falling step whose result would reach or pass the lower bound loads the lower bound. A borrow below zero counts as passing, so the value never wraps below zero.
- R8: While `hold_i` is 1, the accumulator and the rate timer stay frozen. The prescaler keeps running.
- R9: With the high no-dwell bit set, a rising step that reaches the upper bound loads the lower bound instead.
- R10: With the low no-dwell bit set, a falling step that reaches the lower bound loads the upper bound instead.
- R11: While the working clear bit and the enable bit are both 1, the accumulator is forced to 0 on every clock.
- R12: An update edge with `autoclr_i` = 1 and `ena_i` = 1 zeroes the accumulator at that same edge. This takes priority over any step.
- R13: `at_lim_o` is 1 exactly when the sweep is enabled and `ramp_o` equals the upper bound (for `dir_i` = 1) or the lower bound (for `dir_i` = 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_i | input | 1 | Update strobe: copy staged inputs into the working set |
| lim_lo_i | input | 32 | Staged lower bound |
| lim_hi_i | input | 32 | Staged upper bound |
| step_up_i | input | 32 | Staged rising step size |
| step_dn_i | input | 32 | Staged falling step size |
| per_up_i | input | 16 | Staged rising timer period, in slow ticks |
| per_dn_i | input | 16 | Staged falling timer period, in slow ticks |
| ena_i | input | 1 | Staged sweep enable |
| nd_hi_i | input | 1 | Staged no-dwell at upper bound |
| nd_lo_i | input | 1 | Staged no-dwell at lower bound |
| clr_i | input | 1 | Staged continuous clear |
| autoclr_i | input | 1 | Clear the accumulator at this update edge |
| dir_i | input | 1 | 1 = rise toward upper bound, 0 = fall toward lower bound |
| hold_i | input | 1 | Freeze the sweep while 1 |
| ramp_o | output | 32 | Present sweep value |
| at_lim_o | output | 1 | Sweep sits on the bound of the current direction |

## Verification
The bench builds the block with its defaults: a 32-bit accumulator, 16-bit periods and a divide-by-4 slow tick. With periods of 0 to 3, a full sweep between bounds a few hundred apart completes in a few hundred clocks, so dwell, snap-back, freeze and direction reversal all fit in a short run. Steps of half the 32-bit range, with an upper bound just below all-ones and a lower bound of zero, push the one-bit-wider sum and the borrow path into saturation.

// File: rtl/drg_pkg.sv
// Shared types of the timed ramp generator.
// Assumes: control flags are latched together with the numeric settings.
package drg_pkg;

    // Working control flags of the sweep.
    typedef struct packed {
        logic ena;    // sweep enable
        logic nd_hi;  // snap to lower bound on reaching upper bound
        logic nd_lo;  // snap to upper bound on reaching lower bound
        logic clr;    // force accumulator to zero every clock
    } drg_ctrl_t;

endpackage

// File: rtl/drg_shadow.sv
// Working copy of the sweep settings, loaded from staged inputs on the update strobe.
// Assumes: staged inputs are stable around the clock edge where upd_i is high.
module drg_shadow
    import drg_pkg::*;
#(
    parameter int unsigned ACC_W = 32,
    parameter int unsigned PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_i,
    input  logic [ACC_W-1:0] lim_lo_i,
    input  logic [ACC_W-1:0] lim_hi_i,
    input  logic [ACC_W-1:0] step_up_i,
    input  logic [ACC_W-1:0] step_dn_i,
    input  logic [PER_W-1:0] per_up_i,
    input  logic [PER_W-1:0] per_dn_i,
    input  drg_ctrl_t        ctl_i,
    output logic [ACC_W-1:0] lim_lo_o,
    output logic [ACC_W-1:0] lim_hi_o,
    output logic [ACC_W-1:0] step_up_o,
    output logic [ACC_W-1:0] step_dn_o,
    output logic [PER_W-1:0] per_up_o,
    output logic [PER_W-1:0] per_dn_o,
    output drg_ctrl_t        ctl_o
);

    // Load every setting at once on the update strobe; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_lo_o  <= '0;
            lim_hi_o  <= '0;
            step_up_o <= '0;
            step_dn_o <= '0;
            per_up_o  <= '0;
            per_dn_o  <= '0;
            ctl_o     <= '0;
        end else if (upd_i) begin
            lim_lo_o  <= lim_lo_i;
            lim_hi_o  <= lim_hi_i;
            step_up_o <= step_up_i;
            step_dn_o <= step_dn_i;
            per_up_o  <= per_up_i;
            per_dn_o  <= per_dn_i;
            ctl_o     <= ctl_i;
        end
    end

endmodule

// File: rtl/drg_pacer.sv
// Slow-tick prescaler plus per-direction rate timer; pulses fire_o when a step is due.
// Assumes: a period of 0 means 1; while run_i is low both counters sit at zero.
module drg_pacer #(
    parameter int unsigned PER_W   = 16,
    parameter int unsigned CLK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             hold_i,
    input  logic             dir_i,
    input  logic [PER_W-1:0] per_up_i,
    input  logic [PER_W-1:0] per_dn_i,
    output logic             fire_o
);

    localparam int unsigned PS_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic             tick;
    logic [PER_W-1:0] tmr_q;
    logic [PER_W-1:0] per_sel;
    logic [PER_W:0]   per_eff;
    logic [PER_W:0]   tmr_inc;

    generate
        if (CLK_DIV > 1) begin : g_div
            logic [PS_W-1:0] ps_q;

            // Count system clocks so that one slow tick occurs every CLK_DIV clocks.
            always_ff @(posedge clk) begin
                if (!rst_n || !run_i) begin
                    ps_q <= '0;
                end else if (ps_q == PS_W'(CLK_DIV - 1)) begin
                    ps_q <= '0;
                end else begin
                    ps_q <= ps_q + 1'b1;
                end
            end

            assign tick = run_i && (ps_q == PS_W'(CLK_DIV - 1));
        end else begin : g_nodiv
            assign tick = run_i;
        end
    endgenerate

    // Select the period of the current direction, treating zero as one.
    always_comb begin
        per_sel = dir_i ? per_up_i : per_dn_i;
        per_eff = (per_sel == '0) ? (PER_W+1)'(1) : {1'b0, per_sel};
        tmr_inc = {1'b0, tmr_q} + (PER_W+1)'(1);
        fire_o  = tick && !hold_i && (tmr_inc >= per_eff);
    end

    // Rate timer: advances on unfrozen slow ticks and restarts when a step fires.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            tmr_q <= '0;
        end else if (tick && !hold_i) begin
            tmr_q <= fire_o ? '0 : tmr_inc[PER_W-1:0];
        end
    end

endmodule

// File: rtl/drg_accum.sv
// Sweep accumulator with saturating steps, optional snap-back at each bound and clears.
// Assumes: aclr_i is already qualified by the update strobe and the staged enable.
module drg_accum #(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic             aclr_i,
    input  logic             fire_i,
    input  logic             dir_i,
    input  logic             nd_hi_i,
    input  logic             nd_lo_i,
    input  logic [ACC_W-1:0] lim_lo_i,
    input  logic [ACC_W-1:0] lim_hi_i,
    input  logic [ACC_W-1:0] step_up_i,
    input  logic [ACC_W-1:0] step_dn_i,
    output logic [ACC_W-1:0] acc_o
);

    logic [ACC_W:0]   sum_w;
    logic [ACC_W:0]   dif_w;
    logic [ACC_W-1:0] rise_nxt;
    logic [ACC_W-1:0] fall_nxt;

    // Compute the next rising and falling values with one guard bit against wrap.
    always_comb begin
        sum_w = {1'b0, acc_o} + {1'b0, step_up_i};
        dif_w = {1'b0, acc_o} - {1'b0, step_dn_i};
        if (sum_w >= {1'b0, lim_hi_i}) begin
            rise_nxt = nd_hi_i ? lim_lo_i : lim_hi_i;
        end else begin
            rise_nxt = sum_w[ACC_W-1:0];
        end
        if (dif_w[ACC_W] || (dif_w[ACC_W-1:0] <= lim_lo_i)) begin
            fall_nxt = nd_lo_i ? lim_hi_i : lim_lo_i;
        end else begin
            fall_nxt = dif_w[ACC_W-1:0];
        end
    end

    // Accumulator update: autoclear first, then clear, then a paced step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o <= '0;
        end else if (aclr_i) begin
            acc_o <= '0;
        end else if (run_i) begin
            if (clr_i) begin
                acc_o <= '0;
            end else if (fire_i) begin
                acc_o <= dir_i ? rise_nxt : fall_nxt;
            end
        end
    end

endmodule

// File: rtl/drg_top.sv
// Timed digital ramp generator: shadowed settings, paced accumulator and bound flag.
// Assumes: dir_i and hold_i are synchronous to clk; settings change only via upd_i.
module drg_top
    import drg_pkg::*;
#(
    parameter int unsigned ACC_W   = 32,
    parameter int unsigned PER_W   = 16,
    parameter int unsigned CLK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_i,
    input  logic [ACC_W-1:0] lim_lo_i,
    input  logic [ACC_W-1:0] lim_hi_i,
    input  logic [ACC_W-1:0] step_up_i,
    input  logic [ACC_W-1:0] step_dn_i,
    input  logic [PER_W-1:0] per_up_i,
    input  logic [PER_W-1:0] per_dn_i,
    input  logic             ena_i,
    input  logic             nd_hi_i,
    input  logic             nd_lo_i,
    input  logic             clr_i,
    input  logic             autoclr_i,
    input  logic             dir_i,
    input  logic             hold_i,
    output logic [ACC_W-1:0] ramp_o,
    output logic             at_lim_o
);

    drg_ctrl_t        ctl_stg;
    drg_ctrl_t        ctl_q;
    logic [ACC_W-1:0] lim_lo_q;
    logic [ACC_W-1:0] lim_hi_q;
    logic [ACC_W-1:0] step_up_q;
    logic [ACC_W-1:0] step_dn_q;
    logic [PER_W-1:0] per_up_q;
    logic [PER_W-1:0] per_dn_q;
    logic             fire;
    logic             aclr;

    // Pack the staged control flags.
    always_comb begin
        ctl_stg.ena   = ena_i;
        ctl_stg.nd_hi = nd_hi_i;
        ctl_stg.nd_lo = nd_lo_i;
        ctl_stg.clr   = clr_i;
    end

    assign aclr = upd_i && ena_i && autoclr_i;

    drg_shadow #(.ACC_W(ACC_W), .PER_W(PER_W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_i     (upd_i),
        .lim_lo_i  (lim_lo_i),
        .lim_hi_i  (lim_hi_i),
        .step_up_i (step_up_i),
        .step_dn_i (step_dn_i),
        .per_up_i  (per_up_i),
        .per_dn_i  (per_dn_i),
        .ctl_i     (ctl_stg),
        .lim_lo_o  (lim_lo_q),
        .lim_hi_o  (lim_hi_q),
        .step_up_o (step_up_q),
        .step_dn_o (step_dn_q),
        .per_up_o  (per_up_q),
        .per_dn_o  (per_dn_q),
        .ctl_o     (ctl_q)
    );

    drg_pacer #(.PER_W(PER_W), .CLK_DIV(CLK_DIV)) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (ctl_q.ena),
        .hold_i   (hold_i),
        .dir_i    (dir_i),
        .per_up_i (per_up_q),
        .per_dn_i (per_dn_q),
        .fire_o   (fire)
    );

    drg_accum #(.ACC_W(ACC_W)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ctl_q.ena),
        .clr_i     (ctl_q.clr),
        .aclr_i    (aclr),
        .fire_i    (fire),
        .dir_i     (dir_i),
        .nd_hi_i   (ctl_q.nd_hi),
        .nd_lo_i   (ctl_q.nd_lo),
        .lim_lo_i  (lim_lo_q),
        .lim_hi_i  (lim_hi_q),
        .step_up_i (step_up_q),
        .step_dn_i (step_dn_q),
        .acc_o     (ramp_o)
    );

    // Flag the bound that the current direction is heading toward.
    assign at_lim_o = ctl_q.ena && (dir_i ? (ramp_o == lim_hi_q) : (ramp_o == lim_lo_q));

endmodule

// File: rtl/drg_checker.sv
// Temporal checks on the ramp generator, attached to drg_top by bind.
// Assumes: the working settings are visible through the top's internal registers.
module drg_checker
    import drg_pkg::*;
#(
    parameter int unsigned ACC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             upd_i,
    input logic             dir_i,
    input logic             hold_i,
    input logic [ACC_W-1:0] ramp_o,
    input logic             at_lim_o,
    input drg_ctrl_t        ctl,
    input logic [ACC_W-1:0] lim_lo,
    input logic [ACC_W-1:0] lim_hi
);

    // R3: disabled sweep keeps its value when no update arrives.
    a_r3_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.ena && !upd_i) |=> $stable(ramp_o));

    // R8: freeze input keeps the value.
    a_r8_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.ena && hold_i && !ctl.clr && !upd_i) |=> $stable(ramp_o));

    // R6: a rising sweep within bounds never passes the upper bound.
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.ena && dir_i && !ctl.clr && !upd_i && (ramp_o <= lim_hi) && (lim_lo <= lim_hi))
        |=> (ramp_o <= $past(lim_hi)));

    // R7: a falling sweep within bounds never passes the lower bound.
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.ena && !dir_i && !ctl.clr && !upd_i && (ramp_o >= lim_lo) && (lim_lo <= lim_hi))
        |=> (ramp_o >= $past(lim_lo)));

    // R11: the clear bit zeroes the accumulator.
    a_r11_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.ena && ctl.clr && !upd_i) |=> (ramp_o == '0));

    // R13 with R6: a flagged upper bound dwells when no-dwell is off.
    a_r13_dwell_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        (at_lim_o && dir_i && !ctl.nd_hi && !ctl.clr && !upd_i) |=> $stable(ramp_o));

endmodule

bind drg_top drg_checker #(.ACC_W(ACC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_i    (upd_i),
    .dir_i    (dir_i),
    .hold_i   (hold_i),
    .ramp_o   (ramp_o),
    .at_lim_o (at_lim_o),
    .ctl      (ctl_q),
    .lim_lo   (lim_lo_q),
    .lim_hi   (lim_hi_q)
);

// File: tb/sim_drg_top.sv
`timescale 1ns/1ps
// Bench for drg_top: behavioural reference model compared on every clock.
module sim_drg_top;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd = 1'b0;
    logic [31:0] lo = '0, hi = '0, su = '0, sd = '0;
    logic [15:0] pu = '0, pd = '0;
    logic        ena = 1'b0, ndh = 1'b0, ndl = 1'b0, clr = 1'b0, aclr = 1'b0;
    logic        dir = 1'b0, hold = 1'b0;
    logic [31:0] ramp;
    logic        at_lim;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    string tag   = "R1";

    // Reference model state.
    longint m_lo, m_hi, m_su, m_sd, m_acc;
    int     m_pu, m_pd, m_p, m_t;
    bit     m_ena, m_ndh, m_ndl, m_clr;

    always #2 clk = ~clk;

    drg_top #(.ACC_W(32), .PER_W(16), .CLK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .upd_i(upd),
        .lim_lo_i(lo), .lim_hi_i(hi), .step_up_i(su), .step_dn_i(sd),
        .per_up_i(pu), .per_dn_i(pd),
        .ena_i(ena), .nd_hi_i(ndh), .nd_lo_i(ndl), .clr_i(clr), .autoclr_i(aclr),
        .dir_i(dir), .hold_i(hold),
        .ramp_o(ramp), .at_lim_o(at_lim)
    );

    // Reference model: advances once per clock from the inputs present at the edge.
    always @(posedge clk) begin
        int     per;
        bit     tick, fire;
        longint nacc, s;
        cyc = cyc + 1;
        if (!rst_n) begin
            m_lo = 0; m_hi = 0; m_su = 0; m_sd = 0; m_acc = 0;
            m_pu = 0; m_pd = 0; m_p = 0; m_t = 0;
            m_ena = 0; m_ndh = 0; m_ndl = 0; m_clr = 0;
        end else begin
            per  = dir ? m_pu : m_pd;
            if (per == 0) per = 1;
            tick = m_ena && (m_p == DIV - 1);
            fire = tick && !hold && (m_t + 1 >= per);
            nacc = m_acc;
            if (upd && ena && aclr) begin
                nacc = 0;
            end else if (m_ena) begin
                if (m_clr) begin
                    nacc = 0;
                end else if (fire) begin
                    if (dir) begin
                        s = m_acc + m_su;
                        nacc = (s >= m_hi) ? (m_ndh ? m_lo : m_hi) : s;
                    end else begin
                        s = m_acc - m_sd;
                        nacc = (s <= m_lo) ? (m_ndl ? m_hi : m_lo) : s;
                    end
                end
            end
            if (!m_ena) begin
                m_p = 0; m_t = 0;
            end else begin
                m_p = (m_p == DIV - 1) ? 0 : m_p + 1;
                if (tick && !hold) m_t = fire ? 0 : m_t + 1;
            end
            m_acc = nacc;
            if (upd) begin
                m_lo = lo; m_hi = hi; m_su = su; m_sd = sd;
                m_pu = pu; m_pd = pd;
                m_ena = ena; m_ndh = ndh; m_ndl = ndl; m_clr = clr;
            end
        end
    end

    // Watchdog: an overlong run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc == 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run did not finish (act %0d cycles, exp < 150000)", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk32(string req, logic [31:0] act, logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act %h exp %h", req, act, exp);
        end
    endtask

    // Compare both outputs with the model; at_lim follows R13.
    task automatic compare();
        logic exp_lim;
        exp_lim = m_ena && (dir ? (m_acc[31:0] == m_hi[31:0]) : (m_acc[31:0] == m_lo[31:0]));
        chk32({tag, " ramp_o"}, ramp, m_acc[31:0]);
        chk32({tag, "/R13 at_lim_o"}, {31'b0, at_lim}, {31'b0, exp_lim});
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
        end
    endtask

    task automatic update();
        upd = 1'b1;
        run(1);
        upd = 1'b0;
    endtask

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk32("R1 ramp_o after reset", ramp, 32'd0);
        chk32("R1 at_lim_o after reset", {31'b0, at_lim}, 32'd0);

        // R2: staged settings without a strobe do nothing.
        tag = "R2";
        lo = 32'd100; hi = 32'd1000; su = 32'd37; sd = 32'd50;
        pu = 16'd2; pd = 16'd3; ena = 1'b1; dir = 1'b1;
        run(40);
        chk32("R2 ramp_o unchanged before strobe", ramp, 32'd0);

        // R4 then R6: rise and dwell at the upper bound.
        tag = "R4";
        update();
        run(80);
        tag = "R6";
        run(400);
        chk32("R6 ramp_o dwells at upper bound", ramp, 32'd1000);
        chk32("R13 at_lim_o at upper bound", {31'b0, at_lim}, 32'd1);

        // R5 and R7: fall to and dwell at the lower bound.
        tag = "R5";
        dir = 1'b0;
        run(100);
        tag = "R7";
        run(500);
        chk32("R7 ramp_o dwells at lower bound", ramp, 32'd100);

        // R8: freeze while rising.
        tag = "R8";
        dir = 1'b1;
        run(20);
        hold = 1'b1;
        run(50);
        hold = 1'b0;
        run(20);

        // R3: disabled sweep ignores clear, direction and freeze.
        tag = "R3";
        ena = 1'b0; clr = 1'b1;
        update();
        clr = 1'b0;
        dir = 1'b0; run(15);
        hold = 1'b1; run(15);
        hold = 1'b0; dir = 1'b1; run(15);

        // R9: snap from upper to lower bound.
        tag = "R9";
        ena = 1'b1; ndh = 1'b1;
        update();
        run(300);

        // R10: snap from lower to upper bound.
        tag = "R10";
        ndh = 1'b0; ndl = 1'b1; dir = 1'b0;
        update();
        run(300);

        // R6/R7 with wide steps: saturation without wrap; period 0 acts as 1.
        tag = "R6";
        ndl = 1'b0; lo = 32'd0; hi = 32'hFFFF_FFF0;
        su = 32'h8000_0000; sd = 32'h9000_0000; pu = 16'd0; pd = 16'd0; dir = 1'b1;
        update();
        run(60);
        chk32("R6 ramp_o saturates below all-ones", ramp, 32'hFFFF_FFF0);
        tag = "R7";
        dir = 1'b0;
        run(60);
        chk32("R7 ramp_o saturates at zero", ramp, 32'd0);

        // R11: continuous clear.
        tag = "R11";
        lo = 32'd100; hi = 32'd1000; su = 32'd37; sd = 32'd50;
        pu = 16'd1; pd = 16'd2; dir = 1'b1;
        update();
        run(40);
        clr = 1'b1;
        update();
        run(20);
        chk32("R11 ramp_o held at zero", ramp, 32'd0);
        clr = 1'b0;
        update();
        run(40);

        // R12: autoclear at the update edge.
        tag = "R12";
        aclr = 1'b1;
        update();
        aclr = 1'b0;
        chk32("R12 ramp_o zero after autoclear strobe", ramp, 32'd0);
        run(60);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule